// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block sits on the host side of an asynchronous DRAM. It brings the memory out of power-up and keeps its contents alive. After reset it holds both strobes inactive for a start-up pause. It then runs a burst of CAS-before-RAS cycles to initialize the array. From then on it issues one CAS-before-RAS refresh per refresh period, so every row is visited within the retention time. The refresh row counter inside the memory supplies the addresses, so no address is driven.

An access client asks for the bus with a level request and receives a grant that stays high until the request drops. The controller drives no strobes while the grant is high. While the client owns the bus, refresh periods accumulate in a small backlog counter. Waiting accesses win over a short backlog. A full backlog blocks new grants until every postponed refresh has been issued.

An idle timer watches the time since the controller last issued a RAS cycle. If a grant holds the bus past that limit, the memory is treated as unclocked. A fresh initialization burst then runs before the next grant.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PAUSE_CYC clock cycles after reset is released, ras_n and cas_n stay high, acc_gnt stays low and ready stays low.
- R2: After the pause, exactly INIT_CNT CAS-before-RAS cycles are issued before the first grant, even if acc_req is already high. ready goes high when the last of them ends.
- R3: With no access traffic, one refresh cycle is issued per REF_PERIOD clock cycles on average.
- R4: Every RAS cycle is CAS-before-RAS. cas_n goes low exactly CAS_LEAD cycles before ras_n falls, and ras_n stays low for exactly RAS_W cycles. cas_n rises with ras_n, and both then stay high for PRE_W cycles.
- R5: A grant rises only while acc_req is high and stays high until acc_req drops. ras_n and cas_n remain high while acc_gnt is high.
- R6: While fewer than MAX_PEND refreshes are pending, a waiting request is granted before the postponed refreshes are issued.
- R7: The pending count saturates at MAX_PEND. Once it reaches MAX_PEND, no grant is given until all pending refreshes have been issued.
- R8: If no RAS cycle is issued for IDLE_LIMIT cycles, ready drops. A new burst of INIT_CNT cycles, followed by the pending refreshes, runs before the next grant.
- R9: During reset, ras_n and cas_n are high and acc_gnt and ready are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset, asserted at power-up |
| acc_req | input | 1 | Access client requests the bus (level) |
| acc_gnt | output | 1 | Bus granted to the access client |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| ready | output | 1 | Initialization complete and not expired |

## Verification
Several properties are checked on every cycle: silent strobes during the pause, CAS low at every RAS fall, quiet strobes under a grant, the backlog cap, no grant out of an idle state that still needs initialization or is draining the backlog, and the loss of ready after the idle limit. Other behaviour only shows in the bench's scenarios: the exact count of initialization cycles, the average refresh rate, the access-first choice below the cap, and the length of the drain after a long hold. The same goes for the re-initialization that follows an over-long grant.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned PAUSE_CYC  = 40_000_000,
  parameter int unsigned INIT_CNT   = 8,
  parameter int unsigned REF_PERIOD = 3120,
  parameter int unsigned IDLE_LIMIT = 3_200_000,
  parameter int unsigned CAS_LEAD   = 2,
  parameter int unsigned RAS_W      = 10,
  parameter int unsigned PRE_W      = 6,
  parameter int unsigned MAX_PEND   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  output logic acc_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic ready
);

  localparam int unsigned CYC = CAS_LEAD + RAS_W + PRE_W;
  localparam int unsigned PW  = $clog2(PAUSE_CYC + 1);
  localparam int unsigned RW  = $clog2(REF_PERIOD + 1);
  localparam int unsigned IW  = $clog2(IDLE_LIMIT + 1);
  localparam int unsigned CW  = $clog2(CYC + 1);
  localparam int unsigned NW  = $clog2(INIT_CNT + 1);
  localparam int unsigned QW  = $clog2(MAX_PEND + 1);

  typedef enum logic [1:0] {S_PAUSE, S_IDLE, S_CBR, S_GNT} st_t;

  st_t          st;
  logic [PW-1:0] pcnt;
  logic [RW-1:0] rcnt;
  logic [IW-1:0] icnt;
  logic [CW-1:0] ccnt;
  logic [NW-1:0] init_left;
  logic [QW-1:0] pend;
  logic          need_init;
  logic          drain;

  wire tick      = (st != S_PAUSE) && (rcnt == RW'(REF_PERIOD - 1));
  wire cyc_end   = (st == S_CBR) && (ccnt == CW'(CYC - 1));
  wire ref_done  = cyc_end && (init_left == '0);
  wire burst_end = cyc_end && (init_left == NW'(1));
  wire at_cap    = (pend == QW'(MAX_PEND));
  wire idle_exp  = (st == S_IDLE || st == S_GNT) && (icnt == IW'(IDLE_LIMIT - 1));

  assign acc_gnt = (st == S_GNT);
  assign cas_n   = !((st == S_CBR) && (ccnt < CW'(CAS_LEAD + RAS_W)));
  assign ras_n   = !((st == S_CBR) && (ccnt >= CW'(CAS_LEAD)) && (ccnt < CW'(CAS_LEAD + RAS_W)));
  assign ready   = (st != S_PAUSE) && !need_init;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      pcnt      <= '0;
      ccnt      <= '0;
      init_left <= '0;
    end else begin
      case (st)
        S_PAUSE: begin
          if (pcnt == PW'(PAUSE_CYC - 1)) st <= S_IDLE;
          else pcnt <= pcnt + 1'b1;
        end
        S_IDLE: begin
          ccnt <= '0;
          if (need_init) begin
            if (init_left == '0) init_left <= NW'(INIT_CNT);
            st <= S_CBR;
          end else if (at_cap || (drain && pend != '0)) st <= S_CBR;
          else if (acc_req) st <= S_GNT;
          else if (pend != '0) st <= S_CBR;
        end
        S_CBR: begin
          ccnt <= ccnt + 1'b1;
          if (cyc_end) begin
            st <= S_IDLE;
            if (init_left != '0) init_left <= init_left - 1'b1;
          end
        end
        default: if (!acc_req) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st == S_PAUSE) rcnt <= '0;
    else if (tick) rcnt <= '0;
    else rcnt <= rcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st == S_PAUSE || st == S_CBR) icnt <= '0;
    else if (!idle_exp) icnt <= icnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      drain     <= 1'b0;
      need_init <= 1'b1;
    end else begin
      if (tick && !ref_done && !at_cap) pend <= pend + 1'b1;
      else if (ref_done && !tick) pend <= pend - 1'b1;
      if (at_cap) drain <= 1'b1;
      else if (pend == '0) drain <= 1'b0;
      if (idle_exp) need_init <= 1'b1;
      else if (burst_end) need_init <= 1'b0;
    end
  end

  p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE) |-> (ras_n && cas_n && !acc_gnt && !ready));

  p_init_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && need_init) |=> !acc_gnt);

  p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n);

  p_grant_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (ras_n && cas_n));

  p_grant_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_gnt && acc_req) |=> acc_gnt);

  p_pend_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= QW'(MAX_PEND));

  p_drain_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && drain && pend != '0) |=> !acc_gnt);

  p_reinit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_exp |=> !ready);

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int PAUSE = 50, INIT = 8, REFP = 60, IDLE = 300;
  localparam int LEAD = 2, RASW = 4, PREW = 2, MAXP = 3;

  logic clk = 1'b0, rst_n = 1'b0, acc_req = 1'b0;
  logic acc_gnt, ras_n, cas_n, ready;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .REF_PERIOD(REFP),
    .IDLE_LIMIT(IDLE), .CAS_LEAD(LEAD), .RAS_W(RASW), .PRE_W(PREW), .MAX_PEND(MAXP))
  dut_i (.clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_gnt(acc_gnt),
         .ras_n(ras_n), .cas_n(cas_n), .ready(ready));

  int checks = 0, errors = 0, cyc = 0, first_cyc = -1;
  int r_total = 0, cas_lead = 0, ras_w = 0;
  logic prev_ras = 1'b1, prev_gnt = 1'b0;
  byte exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input byte e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic sb_pop(input byte got);
    byte e;
    string t;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(e == got, t, int'(got), int'(e));
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!cas_n && first_cyc < 0) first_cyc = cyc;
      if (!ras_n && prev_ras) begin
        r_total++;
        check(!cas_n, "R4 cas low at ras fall", int'(cas_n), 0);
        check(cas_lead == LEAD, "R4 cas lead", cas_lead, LEAD);
        sb_pop("R");
      end
      if (ras_n && !prev_ras) begin
        check(ras_w == RASW, "R4 ras width", ras_w, RASW);
        check(cas_n, "R4 cas rises with ras", int'(cas_n), 1);
        ras_w = 0;
      end
      if (!ras_n) ras_w++;
      if (cas_n) cas_lead = 0;
      else if (ras_n) cas_lead++;
      if (acc_gnt && !prev_gnt) sb_pop("G");
      prev_ras = ras_n;
      prev_gnt = acc_gnt;
    end
  end

  task automatic wait_ras_cycle();
    do @(negedge clk); while (ras_n);
    do @(negedge clk); while (!ras_n);
  endtask

  task automatic wait_gnt();
    do @(negedge clk); while (!acc_gnt);
  endtask

  task automatic wait_sb();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int r0, n;
    repeat (4) @(negedge clk);
    check(ras_n && cas_n, "R9 strobes high in reset", int'({ras_n, cas_n}), 3);
    check(!acc_gnt, "R9 no grant in reset", int'(acc_gnt), 0);
    check(!ready, "R9 not ready in reset", int'(ready), 0);

    for (int i = 0; i < INIT; i++) push("R", "R2 init burst");
    push("G", "R2 grant after burst");
    acc_req = 1'b1;
    rst_n = 1'b1;
    repeat (PAUSE / 2) @(negedge clk);
    check(!acc_gnt && !ready, "R1 quiet during pause", int'({acc_gnt, ready}), 0);
    wait_sb();
    check(ready, "R2 ready after burst", int'(ready), 1);
    check(first_cyc >= PAUSE, "R1 pause length", first_cyc, PAUSE);
    check(r_total == INIT, "R2 burst count", r_total, INIT);
    repeat (20) @(negedge clk);
    check(acc_gnt && ras_n && cas_n, "R5 grant held, strobes idle",
          int'({acc_gnt, ras_n, cas_n}), 7);
    acc_req = 1'b0;

    repeat (100) @(negedge clk);
    r0 = r_total;
    repeat (10 * REFP) @(negedge clk);
    n = r_total - r0;
    check(n >= 9 && n <= 11, "R3 refresh rate", n, 10);

    wait_ras_cycle();
    push("G", "R6 access first");
    push("G", "R6 access again");
    r0 = r_total;
    acc_req = 1'b1;
    wait_gnt();
    repeat (30) @(negedge clk);
    acc_req = 1'b0;
    @(negedge clk);
    acc_req = 1'b1;
    wait_sb();
    check(r_total == r0, "R6 no refresh between grants", r_total - r0, 0);
    repeat (10) @(negedge clk);
    acc_req = 1'b0;

    repeat (200) @(negedge clk);
    wait_ras_cycle();
    acc_req = 1'b1;
    repeat (200) @(negedge clk);
    check(acc_gnt, "R5 long grant kept", int'(acc_gnt), 1);
    acc_req = 1'b0;
    @(negedge clk);
    r0 = r_total;
    acc_req = 1'b1;
    wait_gnt();
    n = r_total - r0;
    check(n >= MAXP && n <= MAXP + 1, "R7 backlog drained before grant", n, MAXP);
    check(ready, "R7 still ready", int'(ready), 1);
    repeat (5) @(negedge clk);
    acc_req = 1'b0;

    repeat (200) @(negedge clk);
    wait_ras_cycle();
    acc_req = 1'b1;
    repeat (IDLE + 50) @(negedge clk);
    check(!ready, "R8 ready dropped after idle limit", int'(ready), 0);
    acc_req = 1'b0;
    @(negedge clk);
    r0 = r_total;
    acc_req = 1'b1;
    wait_gnt();
    n = r_total - r0;
    check(n >= INIT + MAXP && n <= INIT + MAXP + 1, "R8 reinit burst before grant", n, INIT + MAXP);
    check(ready, "R8 ready after reinit", int'(ready), 1);
    repeat (5) @(negedge clk);
    acc_req = 1'b0;
    repeat (20) @(negedge clk);

    summary();
    $finish;
  end
endmodule